// File: doc/BRIEF.md
# Idle-Mode Wake-Up Sequencer

This block decides when a processor core that has parked itself in a low-power idle state may run again. A request from the core moves the sequencer out of its running state and drops the run-enable output on the next clock. While idle, it watches the wake sources: maskable interrupt lines gated by an enable mask, a watchdog interrupt and a non-maskable interrupt. A wake is taken either straight from these lines, with a two-cycle minimum width, or through a programmable input qualifier that samples at a slower rate and needs several consecutive high samples.

Once a wake is accepted, the block waits a resume latency that depends on where code is fetched from. An active flash and on-chip SRAM need a short delay. A flash that must first leave its sleep state needs a much longer one. When the delay runs out, run-enable rises and a one-cycle resume strobe marks the restart point, which is the instruction after the idle instruction. An external reset input overrides everything and puts the block back into the running state at once. The memory mode and qualifier settings are captured when idle is entered.

Top module: `idle_wake_seq`

## Requirements
- R1: After synchronous reset, run_en is 1 and resume is 0.
- R2: In the running state, idle_req drops run_en at the next clock edge, and no resume strobe is produced.
- R3: With the qualifier off, a wake source (an enabled bit of irq_in, wdog_irq or nmi_in) is accepted at the second consecutive clock edge that samples it high. A pulse that is high at only one edge is ignored.
- R4: An irq_in bit whose irq_en bit is 0 cannot wake the block, however long it is held.
- R5: The resume strobe rises at the L-th clock edge after the accepting edge. L is 8 for mem_mode 0 (flash active) and for mem_mode 2 or 3 (SRAM), and L is 1050 for mem_mode 1 (flash asleep).
- R6: resume is high for exactly one cycle, in the same cycle that run_en returns to 1.
- R7: With qual_en set, the wake line is sampled once every 2*qual_prd cycles (every cycle when qual_prd is 0). A wake is accepted at the sixth consecutive high sample. A pulse shorter than 1 + 10*qual_prd cycles is therefore ignored.
- R8: ext_rst forces run_en to 1 and resume to 0 at the next edge from any state. It discards any latency count in progress, and it wins over a count that expires in the same cycle.
- R9: mem_mode, qual_en and qual_prd are captured at the idle-entry edge. Changing them while idle does not alter the resume latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req | input | 1 | Core asks to enter idle |
| irq_in | input | N_IRQ | Maskable interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enable mask |
| wdog_irq | input | 1 | Watchdog interrupt wake source |
| nmi_in | input | 1 | Non-maskable interrupt wake source |
| ext_rst | input | 1 | External reset wake, overrides all other logic |
| qual_en | input | 1 | Route wake sources through the input qualifier |
| qual_prd | input | QPRD_W | Qualifier sampling period setting |
| mem_mode | input | 2 | Code memory: 0 flash active, 1 flash asleep, 2/3 SRAM |
| run_en | output | 1 | Core may execute |
| resume | output | 1 | One-cycle strobe when execution restarts after idle |

## Verification
The external reset override and the end of the latency count can happen in the same cycle. Both try to return the block to the running state, but only the count expiry should raise the resume strobe. The bench starts a short-latency wake and drives ext_rst so that it is sampled at exactly the edge where resume would have risen. At that edge it expects run_en high with resume low, and it expects resume still low on the following edge. A bound assertion separately requires every resume strobe to follow an expiry of the count, and every ext_rst to be followed by a cycle with no strobe.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAKE = 2'd2
  } iw_state_t;

  // memory mode encoding: 0 flash active, 1 flash asleep, 2/3 SRAM
  function automatic int unsigned resume_latency(input logic [1:0] mode,
                                                 input int unsigned fast_lat,
                                                 input int unsigned slow_lat);
    return (mode == 2'd1) ? slow_lat : fast_lat;
  endfunction

  // cycles between qualifier samples; a zero setting samples every cycle
  function automatic int unsigned sample_period(input int unsigned prd);
    return (prd == 0) ? 1 : 2 * prd;
  endfunction

endpackage

// File: rtl/iws_wake_filter.sv
module iws_wake_filter #(
  parameter int QPRD_W    = 8,
  parameter int QUAL_HITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              wake_raw,
  input  logic              qual_en,
  input  logic [QPRD_W-1:0] qual_prd,
  output logic              accept
);
  import idle_wake_pkg::*;

  localparam int QC_W = QPRD_W + 2;
  localparam int HW   = $clog2(QUAL_HITS + 1);

  logic            prev_hi;
  logic [QC_W-1:0] qcnt;
  logic [QC_W-1:0] period;
  logic [HW-1:0]   hits;
  logic            tick;

  assign period = QC_W'(sample_period(int'(qual_prd)));
  assign tick   = (qcnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      prev_hi <= 1'b0;
      qcnt    <= '0;
      hits    <= '0;
    end else begin
      prev_hi <= wake_raw;
      qcnt    <= tick ? (period - 1'b1) : (qcnt - 1'b1);
      if (tick) begin
        if (!wake_raw)                   hits <= '0;
        else if (hits != HW'(QUAL_HITS)) hits <= hits + 1'b1;
      end
    end
  end

  always_comb begin
    if (qual_en) accept = arm && tick && wake_raw && (hits == HW'(QUAL_HITS - 1));
    else         accept = arm && wake_raw && prev_hi;
  end

endmodule

// File: rtl/iws_latency_timer.sv
module iws_latency_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)    cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/idle_wake_seq.sv
module idle_wake_seq #(
  parameter int N_IRQ    = 8,
  parameter int QPRD_W   = 8,
  parameter int FAST_LAT = 8,
  parameter int SLOW_LAT = 1050
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic              wdog_irq,
  input  logic              nmi_in,
  input  logic              ext_rst,
  input  logic              qual_en,
  input  logic [QPRD_W-1:0] qual_prd,
  input  logic [1:0]        mem_mode,
  output logic              run_en,
  output logic              resume
);
  import idle_wake_pkg::*;

  localparam int MAX_LAT = (SLOW_LAT > FAST_LAT) ? SLOW_LAT : FAST_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  iw_state_t         state;
  logic [1:0]        mode_q;
  logic              qen_q;
  logic [QPRD_W-1:0] qprd_q;

  // named internal events
  logic             wake_any;
  logic             armed;
  logic             accept;
  logic             expire;
  logic             cnt_zero;
  logic             enter_idle;
  logic [CNT_W-1:0] lat_load;

  assign wake_any   = (|(irq_in & irq_en)) | wdog_irq | nmi_in;
  assign armed      = (state == ST_IDLE);
  assign enter_idle = (state == ST_RUN) && idle_req && !ext_rst;
  assign expire     = (state == ST_WAKE) && cnt_zero;
  assign lat_load   = CNT_W'(resume_latency(mode_q, FAST_LAT, SLOW_LAT) - 1);

  iws_wake_filter #(.QPRD_W(QPRD_W), .QUAL_HITS(6)) u_filter (
    .clk      (clk),
    .rst      (rst),
    .arm      (armed),
    .wake_raw (wake_any),
    .qual_en  (qen_q),
    .qual_prd (qprd_q),
    .accept   (accept)
  );

  iws_latency_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (ext_rst),
    .load     (accept && !ext_rst),
    .load_val (lat_load),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_RUN;
      run_en <= 1'b1;
      resume <= 1'b0;
      mode_q <= 2'd0;
      qen_q  <= 1'b0;
      qprd_q <= '0;
    end else if (ext_rst) begin
      state  <= ST_RUN;
      run_en <= 1'b1;
      resume <= 1'b0;
    end else begin
      resume <= 1'b0;
      unique case (state)
        ST_RUN: if (idle_req) begin
          state  <= ST_IDLE;
          run_en <= 1'b0;
          mode_q <= mem_mode;
          qen_q  <= qual_en;
          qprd_q <= qual_prd;
        end
        ST_IDLE: if (accept) state <= ST_WAKE;
        ST_WAKE: if (cnt_zero) begin
          state  <= ST_RUN;
          run_en <= 1'b1;
          resume <= 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/iws_chk.sv
module iws_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_rst,
  input logic       run_en,
  input logic       resume,
  input logic       enter_idle,
  input logic       accept,
  input logic       expire,
  input logic [1:0] state
);
  // R2
  // drop_run_chk
  drop_run_chk: assert property (@(posedge clk) disable iff (rst)
    enter_idle |=> !run_en && !resume);

  // R6
  // one_shot_chk
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume);

  // R6
  // resume_runs_chk
  resume_runs_chk: assert property (@(posedge clk) disable iff (rst)
    resume |-> run_en);

  // R5
  // resume_cause_chk
  resume_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(resume) |-> $past(expire) && !$past(ext_rst));

  // R8
  // override_chk
  override_chk: assert property (@(posedge clk) disable iff (rst)
    ext_rst |=> run_en && !resume);

  // R3
  // accept_move_chk
  accept_move_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !ext_rst) |=> (state == 2'd2) && !run_en);
endmodule

bind idle_wake_seq iws_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ext_rst    (ext_rst),
  .run_en     (run_en),
  .resume     (resume),
  .enter_idle (enter_idle),
  .accept     (accept),
  .expire     (expire),
  .state      (state)
);

// File: tb/idle_wake_seq_test.sv
module idle_wake_seq_test;
  localparam int NI = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          idle_req = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [NI-1:0] irq_en = 8'b0000_0001;
  logic          wdog_irq = 1'b0;
  logic          nmi_in = 1'b0;
  logic          ext_rst = 1'b0;
  logic          qual_en = 1'b0;
  logic [7:0]    qual_prd = '0;
  logic [1:0]    mem_mode = '0;
  logic          run_en;
  logic          resume;

  int checks = 0;
  int errors = 0;

  idle_wake_seq uut (
    .clk(clk), .rst(rst), .idle_req(idle_req), .irq_in(irq_in), .irq_en(irq_en),
    .wdog_irq(wdog_irq), .nmi_in(nmi_in), .ext_rst(ext_rst), .qual_en(qual_en),
    .qual_prd(qual_prd), .mem_mode(mem_mode), .run_en(run_en), .resume(resume)
  );

  always #2 clk = ~clk;

  // vector table: mode, source (0 irq bit0, 1 watchdog, 2 nmi), expected edge of resume
  localparam int NV = 4;
  localparam int TV_MODE[NV] = '{0, 2, 1, 3};
  localparam int TV_SRC [NV] = '{0, 1, 2, 0};
  localparam int TV_EXP [NV] = '{10, 10, 1052, 10};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int src, input logic v);
    case (src)
      0: irq_in[0] = v;
      1: wdog_irq = v;
      2: nmi_in = v;
      default: irq_in[5] = v;   // bit 5 is masked
    endcase
  endtask

  task automatic go_idle(input logic [1:0] m, input logic qe, input logic [7:0] qp);
    @(negedge clk);
    mem_mode = m; qual_en = qe; qual_prd = qp; idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    chk(run_en == 1'b0 && resume == 1'b0, "R2", run_en, 0);
  endtask

  // drive source for 'hold' edges, return the edge count at which run_en rose (0 if none)
  task automatic pulse_wait(input int src, input int hold, input int maxw, output int n);
    n = 0;
    @(negedge clk);
    set_src(src, 1'b1);
    for (int i = 1; i <= maxw; i++) begin
      @(posedge clk);
      #1;
      if (i == hold) set_src(src, 1'b0);
      if (run_en && n == 0) begin
        n = i;
        break;
      end
    end
    set_src(src, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(run_en == 1'b1, "R1 run_en", run_en, 1);
    chk(resume == 1'b0, "R1 resume", resume, 0);

    // table walk: R3, R5, R6
    for (int k = 0; k < NV; k++) begin
      go_idle(TV_MODE[k][1:0], 1'b0, 8'd0);
      pulse_wait(TV_SRC[k], 2, 1200, n);
      chk(n == TV_EXP[k], "R5 latency", n, TV_EXP[k]);
      chk(resume == 1'b1, "R6 strobe with run_en", resume, 1);
      @(posedge clk); #1;
      chk(resume == 1'b0, "R6 single cycle", resume, 0);
    end

    // R3: one-edge pulse ignored, then a proper one wakes
    go_idle(2'd0, 1'b0, 8'd0);
    pulse_wait(2, 1, 30, n);
    chk(n == 0, "R3 short pulse", n, 0);
    // R4: masked line held long
    pulse_wait(3, 20, 40, n);
    chk(n == 0, "R4 masked irq", n, 0);
    pulse_wait(1, 2, 40, n);
    chk(n == 10, "R3 wake after ignored pulses", n, 10);

    // R9: change mode while idle
    go_idle(2'd0, 1'b0, 8'd0);
    @(negedge clk);
    mem_mode = 2'd1; qual_en = 1'b1; qual_prd = 8'd7;
    pulse_wait(0, 2, 1200, n);
    chk(n == 10, "R9 settings captured", n, 10);

    // R7: qualifier, period setting 1 -> sample every 2 cycles
    go_idle(2'd2, 1'b1, 8'd1);
    pulse_wait(0, 3, 30, n);
    chk(n == 0, "R7 3-cycle pulse", n, 0);
    pulse_wait(0, 10, 30, n);
    chk(n == 0, "R7 10-cycle pulse below 11", n, 0);
    pulse_wait(0, 40, 60, n);
    chk(n >= 19 && n <= 20, "R7 qualified latency", n, 19);
    // R7: setting 0 samples every cycle: sixth sample at edge 6, resume at 14
    go_idle(2'd0, 1'b1, 8'd0);
    pulse_wait(0, 5, 30, n);
    chk(n == 0, "R7 5-sample pulse", n, 0);
    pulse_wait(0, 20, 30, n);
    chk(n == 14, "R7 zero period", n, 14);

    // R8: override mid-count, count discarded
    go_idle(2'd1, 1'b0, 8'd0);
    pulse_wait(0, 2, 100, n);
    chk(n == 0, "R8 still counting", n, 0);
    @(negedge clk);
    ext_rst = 1'b1;
    @(posedge clk); #1;
    chk(run_en == 1'b1 && resume == 1'b0, "R8 override", {run_en, resume}, 2);
    @(negedge clk);
    ext_rst = 1'b0;
    n = 0;
    for (int i = 0; i < 1100; i++) begin
      @(posedge clk); #1;
      if (resume) n++;
    end
    chk(n == 0, "R8 count discarded", n, 0);

    // R8: override in the cycle the count expires (edge 10)
    go_idle(2'd0, 1'b0, 8'd0);
    @(negedge clk);
    irq_in[0] = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      @(posedge clk); #1;
      if (i == 2) irq_in[0] = 1'b0;
    end
    @(negedge clk);
    ext_rst = 1'b1;
    @(posedge clk); #1;
    chk(run_en == 1'b1, "R8 coincide run_en", run_en, 1);
    chk(resume == 1'b0, "R8 coincide no strobe", resume, 0);
    @(negedge clk);
    ext_rst = 1'b0;
    @(posedge clk); #1;
    chk(resume == 1'b0, "R8 no late strobe", resume, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule